// File: doc/BRIEF.md
# Ready-Edge Interrupt Controller

This block turns the ready/busy line of a NAND flash device into a maskable host interrupt. The line is low while the device is busy with a long operation such as erase or program, and it returns high when the device is done. The block passes the line through a flop synchronizer and looks for a low-to-high change on the synchronized copy. Each such change latches a ready event into a status register. One level interrupt output is driven from that status, gated by a mask register.

Software keeps the interrupt masked by default. Before starting a long operation it writes ones to the status register to throw away stale events, then writes the value 0x81 to the mask to arm the interrupt. The handler writes 0x00 to the mask to silence it again. The current busy level can be read at any time in bit 7 of the status register, whatever the interrupt state is. Register access is a single-cycle write strobe and a combinational read, both selected by one address bit.

Top module: `rdy_irq_ctrl`

## Requirements
- R1: After reset the status reads 0x00 (with rb_i high), the mask reads 0x00 and irq_o is low.
- R2: Status read (addr_i=0) bit 7 is 1 while the synchronized ready/busy line is low (busy) and 0 while it is high. It follows rb_i two clock edges after rb_i changes. Bits 6:4 read 0.
- R3: rb_i passes through two synchronizer flops and one edge-history flop. A low-to-high change applied before clock edge k sets status bit 0, and it reads back as set after edge k+2 and not before.
- R4: Only a low-to-high change sets status bit 0. A high-to-low change, or a level held steady, leaves the bit unchanged.
- R5: Status bits clear on write-one. Writing 1 to bit 0 clears it. Writing 0 leaves it as it is. Bits 3:1 have no event source and always read 0.
- R6: When a clear of bit 0 and a new rising edge fall in the same cycle, bit 0 ends up set.
- R7: A write to the mask (addr_i=1) stores all 8 bits, and a read returns them unchanged.
- R8: irq_o = mask[7] & |(status[3:0] & mask[3:0]). So 0x81 arms the ready interrupt, 0x00 silences everything, and bit 0 or bit 7 alone does not raise irq_o.
- R9: Status bit 0 is captured even while the interrupt is masked. Arming the mask afterwards raises irq_o in the same cycle the mask write takes effect.
- R10: The synchronizer and edge-history flops reset to the ready level, so releasing reset with rb_i high produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rb_i | input | 1 | Ready/busy from the flash device; high means ready (asynchronous) |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 1 | Register select: 0 selects status, 1 selects mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Level interrupt output |

## Verification
The gating function is swept over all 256 mask values, once with the ready event pending and once without. This separates the global enable bit from the source bit and catches any stray bit that leaks into the AND term. The edge detector is driven with falling edges, held levels and rising edges, and the status is sampled one edge before and exactly at the expected cycle, so a change in synchronizer depth or edge polarity shows up. A clear write is lined up with a rising edge to show that the event wins over the clear. A masked-capture sequence arms the mask after the event has already been latched, which separates a level-gated output from an edge-pulse one.

// File: rtl/rdy_irq_pkg.sv
`timescale 1ns/1ps
package rdy_irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned N_SRC   = 4;
  localparam int unsigned GLB_BIT = 7;
  localparam int unsigned BSY_BIT = 7;
  localparam int unsigned RDY_SRC = 0;

  typedef enum logic {
    SEL_STAT = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/rdy_sync.sv
`timescale 1ns/1ps
module rdy_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rdy_edge.sv
`timescale 1ns/1ps
module rdy_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/rdy_irq_regs.sv
`timescale 1ns/1ps
module rdy_irq_regs
  import rdy_irq_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned NSRC   = N_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   set_i,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   status_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [NSRC-1:0]   status_q;
  logic [NSRC-1:0]   clr;
  logic [DATA_W-1:0] mask_q;

  assign clr = (wr_en_i && sel_i == SEL_STAT) ? wdata_i[NSRC-1:0] : '0;

  // set has priority over a same-cycle write-one clear
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_stat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_q[i] <= 1'b0;
        else         status_q[i] <= set_i[i] | (status_q[i] & ~clr[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (wr_en_i && sel_i == SEL_MASK) mask_q <= wdata_i;
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/rdy_irq_ctrl.sv
`timescale 1ns/1ps
module rdy_irq_ctrl
  import rdy_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = REG_W,
  parameter int unsigned NSRC        = N_SRC,
  parameter int unsigned GLB         = GLB_BIT,
  parameter int unsigned BSY         = BSY_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rb_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic            rb_s;
  logic            rise;
  logic [NSRC-1:0] src_set;
  logic [NSRC-1:0] status_w;
  logic [DATA_W-1:0] mask_w;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(addr_i);

  rdy_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rb_i),
    .q_o   (rb_s)
  );

  rdy_edge #(.RST_VAL(1'b1)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (rb_s),
    .rise_o(rise)
  );

  // only the ready source is wired; the rest read zero
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == RDY_SRC) begin : g_rdy
        assign src_set[i] = rise;
      end else begin : g_none
        assign src_set[i] = 1'b0;
      end
    end
  endgenerate

  rdy_irq_regs #(.DATA_W(DATA_W), .NSRC(NSRC)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (src_set),
    .wr_en_i (wr_en_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .status_o(status_w),
    .mask_o  (mask_w)
  );

  always_comb begin
    rdata_o = '0;
    if (sel == SEL_MASK) begin
      rdata_o = mask_w;
    end else begin
      rdata_o[NSRC-1:0] = status_w;
      rdata_o[BSY]      = ~rb_s;
    end
  end

  assign irq_o = mask_w[GLB] & (|(status_w & mask_w[NSRC-1:0]));
endmodule

// File: rtl/rdy_irq_ctrl_chk.sv
`timescale 1ns/1ps
module rdy_irq_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSRC   = 4,
  parameter int unsigned GLB    = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              rise,
  input logic [NSRC-1:0]   status_w,
  input logic [DATA_W-1:0] mask_w
);
  // R3 R4: a detected edge latches the ready event
  a_r3_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> status_w[0]);

  // R6: event beats a same-cycle clear
  a_r6_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && wr_en_i && !addr_i && wdata_i[0]) |=> status_w[0]);

  // R5: write-one clears when no edge competes
  a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && wr_en_i && !addr_i && wdata_i[0]) |=> !status_w[0]);

  // R4 R5: status holds without edge or status write
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && !(wr_en_i && !addr_i)) |=> $stable(status_w));

  // R8: no output without global enable
  a_r8_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_w[GLB] |-> !irq_o);

  // R7: mask changes only on a mask write
  a_r7_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i) |=> $stable(mask_w));
endmodule

bind rdy_irq_ctrl rdy_irq_ctrl_chk #(.DATA_W(DATA_W), .NSRC(NSRC), .GLB(GLB)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .rise    (rise),
  .status_w(status_w),
  .mask_w  (mask_w)
);

// File: tb/test_rdy_irq_ctrl.sv
`timescale 1ns/1ps
module test_rdy_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       rb_i;
  logic       wr_en_i;
  logic       addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk_i = ~clk_i;

  rdy_irq_ctrl i_rdy_irq_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rb_i   (rb_i),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr_i = a;
    #0.5;
    v = rdata_o;
  endtask

  task automatic make_event();
    rb_i = 1'b0; cyc(4);
    rb_i = 1'b1; cyc(4);
  endtask

  initial begin
    logic [7:0] v;
    rb_i = 1'b1; wr_en_i = 1'b0; addr_i = 1'b0; wdata_i = '0; rst_ni = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);

    // R1 reset state
    rd(0, v); chk("R1 status", v, 8'h00);
    rd(1, v); chk("R1 mask", v, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    // R10 no event from reset release
    cyc(5);
    rd(0, v); chk("R10 no spurious event", v, 8'h00);

    // R2 busy bit timing; R4 falling edge sets nothing
    rb_i = 1'b0; cyc(1);
    rd(0, v); chk("R2 busy after one edge", v, 8'h00);
    cyc(1);
    rd(0, v); chk("R2 busy after two edges", v, 8'h80);
    cyc(5);
    rd(0, v); chk("R4 falling/level no event", v, 8'h80);

    // R3 rising edge latency
    rb_i = 1'b1; cyc(2);
    rd(0, v); chk("R3 not yet set", v, 8'h00);
    cyc(1);
    rd(0, v); chk("R3 set at third edge", v, 8'h01);
    cyc(6);
    rd(0, v); chk("R4 held level keeps bit", v, 8'h01);

    // R5 write-one-to-clear
    wr(0, 8'h0E);
    rd(0, v); chk("R5 zero in bit0 keeps", v, 8'h01);
    wr(0, 8'h0F);
    rd(0, v); chk("R5 clear", v, 8'h00);

    // R6 clear coincides with edge
    rb_i = 1'b0; cyc(4);
    rb_i = 1'b1; cyc(2);
    wr(0, 8'h01);
    rd(0, v); chk("R6 edge wins over clear", v, 8'h01);
    wr(0, 8'h01);
    rd(0, v); chk("R6 later clear", v, 8'h00);

    // R7 R8 exhaustive mask sweep, with and without pending event
    for (int st = 0; st < 2; st++) begin
      if (st == 1) make_event();
      for (int m = 0; m < 256; m++) begin
        logic [7:0] mv;
        mv = 8'(m);
        wr(1, mv);
        rd(1, v); chk("R7 mask readback", v, mv);
        chk("R8 irq gating", {7'b0, irq_o}, {7'b0, mv[7] & mv[0] & (st == 1)});
      end
      wr(0, 8'h0F);
    end

    // R8 R9 arm/handle flow
    wr(1, 8'h00);
    wr(0, 8'h0F);
    wr(1, 8'h81);
    chk("R8 armed idle", {7'b0, irq_o}, 8'h00);
    make_event();
    chk("R8 irq on ready", {7'b0, irq_o}, 8'h01);
    wr(1, 8'h00);
    chk("R8 handler masks", {7'b0, irq_o}, 8'h00);
    rd(0, v); chk("R9 status kept while masked", v, 8'h01);
    wr(1, 8'h81);
    chk("R9 rearm raises irq", {7'b0, irq_o}, 8'h01);
    wr(0, 8'h0F);
    chk("R5 clear drops irq", {7'b0, irq_o}, 8'h00);
    wr(1, 8'h00);
    make_event();
    chk("R9 masked capture no irq", {7'b0, irq_o}, 8'h00);
    rd(0, v); chk("R9 masked capture status", v, 8'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule